// File: doc/BRIEF.md
# Command Word Flag Decoder

This block sits behind a serial word decoder on a command/response data bus terminal. Each time the decoder finishes a word it pulses an update strobe and presents the 16-bit word, whether the word passed its sync, coding and parity checks, and whether it carried a command sync. The block latches that outcome. It then raises the terminal flags: word valid, command received, addressed to this terminal, broadcast, and mode code. It also produces a one-cycle pulse that clears the terminal's fail-safe timer whenever an addressed command arrives.

The terminal address comes from five hard-wired pins plus an odd-parity pin. When the active-low parity-check enable is asserted, the block reports the parity result and refuses to recognise its own address if the parity is wrong. For wraparound self-test, the block compares each decoded word with the word the encoder last sent and reports the result on an active-low status output. A synchronous decoder reset, active low, clears every latched result.

Top module: `cmd_flag_decoder`

## Requirements
- R1: After the asynchronous reset `valid_word_no` and `bit_status_no` are 1, and `val_cmd_o`, `rt_en_o`, `bcast_o`, `mode_code_o` and `fail_safe_clr_o` are 0.
- R2: On a clock edge where `word_upd_i` is 1, `valid_word_no` takes the inverse of `word_ok_i` from the next cycle onwards, and holds between updates.
- R3: `val_cmd_o` is 1 after an update with a valid word whose `cmd_sync_i` is 1 (command sync). A valid word with `cmd_sync_i` 0 (data sync) leaves every command flag at 0.
- R4: `rt_en_o` is 1 after a valid command whose bits 15:11 equal `term_addr_i`, provided the address parity is good or the check is disabled. In the cycle right after each such update, `fail_safe_clr_o` pulses for exactly one cycle.
- R5: `bcast_o` is 1 after a valid command whose bits 15:11 are 11111, unless `bcast_inh_ni` is 0.
- R6: `mode_code_o` is 1 after a valid command whose bits 9:5 are all zeros or all ones.
- R7: `odd_par_o` is combinational. While `par_chk_en_ni` is 0, it is the XOR of `term_addr_i` and `addr_par_i`. While `par_chk_en_ni` is 1, it is 0. A failing check with the enable low blocks `rt_en_o`.
- R8: All command flags are gated by word validity. After an update with `word_ok_i` 0, all of them read 0.
- R9: On an update while `wrap_en_i` is 1, `bit_status_no` becomes 0 if the word is valid and equals `tx_word_i`, and becomes 1 otherwise. Updates while `wrap_en_i` is 0 leave it unchanged.
- R10: `dec_rst_ni` at 0 on a clock edge returns all outputs to their R1 values on the next cycle. This overrides an update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_rst_ni | input | 1 | Synchronous decoder reset, active low |
| word_upd_i | input | 1 | One-cycle strobe: decoder finished a word |
| word_ok_i | input | 1 | Decoded word passed sync, coding and parity checks |
| word_i | input | 16 | Decoded word |
| cmd_sync_i | input | 1 | 1 = command/status sync, 0 = data sync |
| term_addr_i | input | 5 | Hard-wired terminal address |
| addr_par_i | input | 1 | Hard-wired address parity bit (odd) |
| par_chk_en_ni | input | 1 | Address parity check enable, active low |
| bcast_inh_ni | input | 1 | Broadcast flag inhibit, active low |
| wrap_en_i | input | 1 | Wraparound self-test active |
| tx_word_i | input | 16 | Word last sent by the encoder |
| valid_word_no | output | 1 | Last word valid, active low |
| val_cmd_o | output | 1 | Valid command received |
| rt_en_o | output | 1 | Valid command addressed to this terminal |
| bcast_o | output | 1 | Valid broadcast command |
| mode_code_o | output | 1 | Valid mode-code command |
| odd_par_o | output | 1 | Address parity check good |
| bit_status_no | output | 1 | Wraparound compare, 0 = words identical |
| fail_safe_clr_o | output | 1 | One-cycle pulse to clear the fail-safe timer |

## Verification
Two functions can act on the same clock edge: a word update and a decoder reset. The bench raises `word_upd_i` with a valid addressed command on the same edge that `dec_rst_ni` is low. It then checks that the valid flag, `rt_en_o`, the fail-safe pulse and the wraparound status all show their reset values on the following cycle. A second overlap is a looped-back status word that carries the terminal's own address. That word sets the wraparound compare and the addressing flags in one update, and the bench checks both results together.

// File: rtl/cmdflag_pkg.sv
package cmdflag_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned ADDR_W = 5;
  parameter int unsigned SA_W   = 5;

  typedef struct packed {
    logic cmd;
    logic rt;
    logic bcast;
    logic mode;
  } flag_t;
endpackage

// File: rtl/term_addr_check.sv
module term_addr_check #(
  parameter int unsigned ADDR_W = cmdflag_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] term_addr_i,
  input  logic              addr_par_i,
  input  logic              par_chk_en_ni,
  output logic              addr_ok_o,
  output logic              odd_par_o
);
  logic par_good;

  assign par_good  = ^{term_addr_i, addr_par_i};
  assign odd_par_o = !par_chk_en_ni && par_good;
  assign addr_ok_o = par_chk_en_ni || par_good;

  // R7: a refused address is only possible while the check is enabled
  assert_refuse_needs_check_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_ok_o |-> (!par_chk_en_ni && !odd_par_o));
endmodule

// File: rtl/cmd_field_decode.sv
module cmd_field_decode
  import cmdflag_pkg::*;
#(
  parameter int unsigned WORD_W = cmdflag_pkg::WORD_W,
  parameter int unsigned ADDR_W = cmdflag_pkg::ADDR_W,
  parameter int unsigned SA_W   = cmdflag_pkg::SA_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              cmd_sync_i,
  input  logic [ADDR_W-1:0] term_addr_i,
  input  logic              addr_ok_i,
  input  logic              bcast_inh_ni,
  output flag_t             flags_o
);
  localparam int unsigned ADDR_LSB = WORD_W - ADDR_W;
  localparam int unsigned SA_LSB   = ADDR_LSB - 1 - SA_W;  // one T/R bit between

  logic [ADDR_W-1:0] addr;
  logic [SA_W-1:0]   sa;

  assign addr = word_i[WORD_W-1:ADDR_LSB];
  assign sa   = word_i[SA_LSB +: SA_W];

  always_comb begin
    flags_o.cmd   = cmd_sync_i;
    flags_o.rt    = cmd_sync_i && addr_ok_i && (addr == term_addr_i);
    flags_o.bcast = cmd_sync_i && (&addr) && bcast_inh_ni;
    flags_o.mode  = cmd_sync_i && ((sa == '0) || (&sa));
  end
endmodule

// File: rtl/wrap_compare.sv
module wrap_compare #(
  parameter int unsigned WORD_W = cmdflag_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic              wrap_en_i,
  input  logic              word_ok_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              bit_status_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                bit_status_no <= 1'b1;
    else if (clr_i)             bit_status_no <= 1'b1;
    else if (upd_i && wrap_en_i) bit_status_no <= !(word_ok_i && (rx_word_i == tx_word_i));
  end

  assert_hold_outside_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(upd_i && wrap_en_i)) |=> $stable(bit_status_no));
  assert_invalid_never_matches_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && upd_i && wrap_en_i && !word_ok_i) |=> bit_status_no);
endmodule

// File: rtl/cmd_flag_decoder.sv
module cmd_flag_decoder
  import cmdflag_pkg::*;
#(
  parameter int unsigned WORD_W = cmdflag_pkg::WORD_W,
  parameter int unsigned ADDR_W = cmdflag_pkg::ADDR_W,
  parameter int unsigned SA_W   = cmdflag_pkg::SA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_rst_ni,
  input  logic              word_upd_i,
  input  logic              word_ok_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              cmd_sync_i,
  input  logic [ADDR_W-1:0] term_addr_i,
  input  logic              addr_par_i,
  input  logic              par_chk_en_ni,
  input  logic              bcast_inh_ni,
  input  logic              wrap_en_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              valid_word_no,
  output logic              val_cmd_o,
  output logic              rt_en_o,
  output logic              bcast_o,
  output logic              mode_code_o,
  output logic              odd_par_o,
  output logic              bit_status_no,
  output logic              fail_safe_clr_o
);
  logic  addr_ok;
  flag_t dec_flags, flags_q;
  logic  valid_q, fs_clr_q;

  term_addr_check #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .term_addr_i, .addr_par_i, .par_chk_en_ni,
    .addr_ok_o(addr_ok), .odd_par_o
  );

  cmd_field_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SA_W(SA_W)) u_fields (
    .word_i, .cmd_sync_i, .term_addr_i, .addr_ok_i(addr_ok), .bcast_inh_ni,
    .flags_o(dec_flags)
  );

  wrap_compare #(.WORD_W(WORD_W)) u_wrap (
    .clk_i, .rst_ni, .clr_i(!dec_rst_ni), .upd_i(word_upd_i), .wrap_en_i,
    .word_ok_i, .rx_word_i(word_i), .tx_word_i, .bit_status_no
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      flags_q  <= '0;
      fs_clr_q <= 1'b0;
    end else if (!dec_rst_ni) begin
      valid_q  <= 1'b0;
      flags_q  <= '0;
      fs_clr_q <= 1'b0;
    end else begin
      fs_clr_q <= 1'b0;
      if (word_upd_i) begin
        valid_q <= word_ok_i;
        if (word_ok_i) begin
          flags_q  <= dec_flags;
          fs_clr_q <= dec_flags.rt;
        end
      end
    end
  end

  // flags only read while the last word is valid
  assign valid_word_no   = !valid_q;
  assign val_cmd_o       = valid_q && flags_q.cmd;
  assign rt_en_o         = valid_q && flags_q.rt;
  assign bcast_o         = valid_q && flags_q.bcast;
  assign mode_code_o     = valid_q && flags_q.mode;
  assign fail_safe_clr_o = fs_clr_q;

  assert_upd_latches_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_rst_ni && word_upd_i) |=> (valid_word_no == !$past(word_ok_i)));
  assert_rt_needs_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_en_o |-> val_cmd_o);
  assert_fs_pulse_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_safe_clr_o |=> !fail_safe_clr_o || $past(word_upd_i));
  assert_bcast_needs_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |-> val_cmd_o);
  assert_mode_needs_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_code_o |-> val_cmd_o);
  assert_dec_reset_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_rst_ni |=> (valid_word_no && !val_cmd_o && !fail_safe_clr_o && bit_status_no));
endmodule

// File: tb/cmd_flag_decoder_tb.sv
module cmd_flag_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dec_rst_ni = 1'b1;
  logic        word_upd_i = 1'b0, word_ok_i = 1'b0, cmd_sync_i = 1'b0;
  logic [15:0] word_i = '0, tx_word_i = '0;
  logic [4:0]  term_addr_i = 5'b01010;
  logic        addr_par_i = 1'b1, par_chk_en_ni = 1'b1, bcast_inh_ni = 1'b1, wrap_en_i = 1'b0;
  logic        valid_word_no, val_cmd_o, rt_en_o, bcast_o, mode_code_o, odd_par_o;
  logic        bit_status_no, fail_safe_clr_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmd_flag_decoder u_dut (
    .clk_i(clk), .rst_ni, .dec_rst_ni, .word_upd_i, .word_ok_i, .word_i, .cmd_sync_i,
    .term_addr_i, .addr_par_i, .par_chk_en_ni, .bcast_inh_ni, .wrap_en_i, .tx_word_i,
    .valid_word_no, .val_cmd_o, .rt_en_o, .bcast_o, .mode_code_o, .odd_par_o,
    .bit_status_no, .fail_safe_clr_o
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // {valid_n, cmd, rt, bcast, mode, bit_n, fsclr}
  function automatic logic [7:0] outs();
    return {1'b0, valid_word_no, val_cmd_o, rt_en_o, bcast_o, mode_code_o, bit_status_no,
            fail_safe_clr_o};
  endfunction

  task automatic send(input logic [15:0] w, input logic cmd, input logic ok);
    @(negedge clk);
    word_i = w; cmd_sync_i = cmd; word_ok_i = ok; word_upd_i = 1'b1;
    @(negedge clk);
    word_upd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", outs(), 8'b0100_0010);
  endtask

  task automatic t_data_word();
    send({5'b01010, 1'b1, 5'b00000, 5'd3}, 1'b0, 1'b1);
    chk("R2 valid low after good word", {7'b0, valid_word_no}, 8'd0);
    chk("R3 data sync raises no command flag", outs(), 8'b0000_0010);
  endtask

  task automatic t_addressed();
    send({5'b01010, 1'b1, 5'b00011, 5'd4}, 1'b1, 1'b1);
    chk("R4 addressed command flags", outs(), 8'b0011_0011);
    @(negedge clk);
    chk("R4 fail-safe clear is one cycle", {7'b0, fail_safe_clr_o}, 8'd0);
    chk("R2 valid holds between updates", {7'b0, valid_word_no}, 8'd0);
    send({5'b00110, 1'b0, 5'b00011, 5'd4}, 1'b1, 1'b1);
    chk("R3 other address: command only", outs(), 8'b0010_0010);
  endtask

  task automatic t_broadcast();
    send({5'b11111, 1'b0, 5'b00010, 5'd1}, 1'b1, 1'b1);
    chk("R5 broadcast flag", {7'b0, bcast_o}, 8'd1);
    chk("R4 broadcast not own address", {7'b0, rt_en_o}, 8'd0);
    bcast_inh_ni = 1'b0;
    send({5'b11111, 1'b0, 5'b00010, 5'd1}, 1'b1, 1'b1);
    chk("R5 broadcast inhibited", {7'b0, bcast_o}, 8'd0);
    chk("R3 command still flagged when inhibited", {7'b0, val_cmd_o}, 8'd1);
    bcast_inh_ni = 1'b1;
  endtask

  task automatic t_mode_code();
    send({5'b01010, 1'b1, 5'b11111, 5'd2}, 1'b1, 1'b1);
    chk("R6 mode code subaddr ones", {7'b0, mode_code_o}, 8'd1);
    send({5'b01010, 1'b1, 5'b00000, 5'd2}, 1'b1, 1'b1);
    chk("R6 mode code subaddr zeros", {7'b0, mode_code_o}, 8'd1);
    send({5'b01010, 1'b1, 5'b10000, 5'd2}, 1'b1, 1'b1);
    chk("R6 ordinary subaddr", {7'b0, mode_code_o}, 8'd0);
  endtask

  task automatic t_parity();
    @(negedge clk);
    chk("R7 check disabled forces low", {7'b0, odd_par_o}, 8'd0);
    par_chk_en_ni = 1'b0; #1;
    chk("R7 good odd parity", {7'b0, odd_par_o}, 8'd1);
    addr_par_i = 1'b0; #1;
    chk("R7 bad parity", {7'b0, odd_par_o}, 8'd0);
    send({5'b01010, 1'b1, 5'b00011, 5'd4}, 1'b1, 1'b1);
    chk("R7 bad parity blocks rt_en", {6'b0, rt_en_o, val_cmd_o}, 8'b01);
    par_chk_en_ni = 1'b1;
    send({5'b01010, 1'b1, 5'b00011, 5'd4}, 1'b1, 1'b1);
    chk("R7 check off accepts address", {7'b0, rt_en_o}, 8'd1);
    addr_par_i = 1'b1;
  endtask

  task automatic t_invalid();
    send({5'b11111, 1'b1, 5'b11111, 5'd0}, 1'b1, 1'b1);
    send({5'b11111, 1'b1, 5'b11111, 5'd0}, 1'b1, 1'b0);
    chk("R8 invalid word gates all flags", outs(), 8'b0100_0010);
  endtask

  task automatic t_wrap();
    wrap_en_i = 1'b1; tx_word_i = 16'hA5C3;
    send(16'hA5C3, 1'b0, 1'b1);
    chk("R9 wrap match", {7'b0, bit_status_no}, 8'd0);
    wrap_en_i = 1'b0;
    send(16'h1234, 1'b0, 1'b1);
    chk("R9 no wrap keeps status", {7'b0, bit_status_no}, 8'd0);
    wrap_en_i = 1'b1;
    send(16'hA5C2, 1'b0, 1'b1);
    chk("R9 wrap mismatch", {7'b0, bit_status_no}, 8'd1);
    send(16'hA5C3, 1'b0, 1'b0);
    chk("R9 invalid word is mismatch", {7'b0, bit_status_no}, 8'd1);
    // looped-back status word carrying own address: compare and flags together
    tx_word_i = {5'b01010, 1'b0, 5'b00100, 5'd0};
    send(tx_word_i, 1'b1, 1'b1);
    chk("R9 R4 looped status word", {5'b0, bit_status_no, rt_en_o, val_cmd_o}, 8'b011);
  endtask

  task automatic t_collision();
    @(negedge clk);
    dec_rst_ni = 1'b0;
    word_i = {5'b01010, 1'b1, 5'b00011, 5'd4}; cmd_sync_i = 1'b1; word_ok_i = 1'b1;
    word_upd_i = 1'b1;
    @(negedge clk);
    word_upd_i = 1'b0; dec_rst_ni = 1'b1;
    chk("R10 decoder reset beats update", outs(), 8'b0100_0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_word();
    t_addressed();
    t_broadcast();
    t_mode_code();
    t_parity();
    t_invalid();
    t_wrap();
    t_collision();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule